// File: doc/BRIEF.md
# Paged Nonvolatile Memory Page-Write Sequencer

This block sits on the host side of a byte-wide paged nonvolatile memory. It writes one burst of 1 to 128 bytes into one page and waits until the memory reports that programming has finished. A client starts a burst with a single-cycle request. The request carries a page number, a starting byte offset inside the page and a byte count. The data bytes then come in over a valid/ready stream.

For each accepted burst the block does four things in order. It first issues three unlock writes, whose addresses and data are parameters. It then writes the data bytes one after another at consecutive offsets of the selected page. Next it reads back the last written address until bit 7 of the returned byte matches bit 7 of the last data byte. Finally it reports success or one of three error kinds. Strobe setup, strobe width and hold are parameter cycle counts. Both the wait for the next stream byte and the number of completion reads are bounded.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset, mem_ce_n, mem_oe_n and mem_we_n are high. mem_dq_oe, busy, done, err and s_ready are low.
- R2: A start request is rejected if its count is 0, its count exceeds 128, or offset plus count exceeds 128. On rejection, err pulses in the next cycle with err_code 1, busy stays low and mem_ce_n never falls.
- R3: An accepted burst begins with three writes, in this order: (0x05555, 0xAA), then (0x02AAA, 0x55), then (0x05555, 0xA0). These are the default unlock parameters, and no data byte is written before them.
- R4: Data byte i is written to address {start_page, start_offset+i}. Page number bits [16:7] are the same for every data write of a burst. A request whose offset plus count is exactly 128 is accepted.
- R5: In every memory write, mem_ce_n is low for SETUP_CYC cycles before mem_we_n falls, and mem_we_n stays low for exactly PULSE_CYC cycles. mem_dq_oe is high during the write, and mem_we_n and mem_oe_n are never low together.
- R6: A stream byte is consumed only in a cycle where both s_valid and s_ready are high. s_ready is high only while a burst is busy. Bytes are written in the order they arrive.
- R7: While waiting for the next data byte, GAP_LIMIT cycles without s_valid end the burst. err pulses with err_code 2, busy falls, and no further write occurs.
- R8: After the last data byte, the block issues reads of the last written address with mem_we_n high. When a read returns bit 7 equal to bit 7 of the last data byte, done pulses.
- R9: The block issues at most POLL_MAX completion reads. A match on read number POLL_MAX still gives done. If no read matches, err pulses with err_code 3.
- R10: busy is high from the cycle after acceptance until the cycle in which done or err pulses, and it is low in that cycle. A start request made while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_valid | input | 1 | Single-cycle burst request |
| start_page | input | 10 | Page number (address bits 16:7) |
| start_offset | input | 7 | First byte offset within the page |
| start_count | input | 8 | Number of bytes, legal 1..128 |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_ready | output | 1 | Stream byte accepted when high with s_valid |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_addr | output | 17 | Memory address |
| mem_dq_out | output | 8 | Data driven to memory |
| mem_dq_oe | output | 1 | High while the block drives the data pins |
| mem_dq_in | input | 8 | Data read from memory |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle pulse on completion |
| err | output | 1 | One-cycle pulse on error |
| err_code | output | 2 | Last error: 1 bad request, 2 stream gap, 3 poll limit |

## Verification
Two outcomes can meet on one read: the completion match and the exhaustion of the completion-read budget. The memory model is set to return an inverted bit 7 for exactly POLL_MAX-1 reads, so the matching read is the last one allowed. The run is judged correct only if done pulses, err stays low and the model counted POLL_MAX reads. A second run moves the match one read later. It must then give err_code 3 after the same number of reads.

// File: rtl/ewr_pkg.sv
// Shared types for the page-write sequencer.
// Assumes: error codes are visible at the top port and are therefore fixed values.
package ewr_pkg;
    typedef enum logic [1:0] {
        ERR_NONE = 2'd0,
        ERR_REQ  = 2'd1,
        ERR_GAP  = 2'd2,
        ERR_POLL = 2'd3
    } ewr_err_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_UNLOCK,
        SQ_LOAD,
        SQ_POLL
    } ewr_seq_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD
    } ewr_phase_e;
endpackage

// File: rtl/ewr_bus_cycle.sv
// Pin-level engine: runs one memory write or read cycle per request.
// The cycle is setup (chip enable low), strobe (write or output enable low),
// then hold. A one-cycle ack follows the last hold cycle.
// Assumes: SETUP_CYC, PULSE_CYC, HOLD_CYC >= 1; req is only raised while idle.
module ewr_bus_cycle
    import ewr_pkg::*;
#(
    parameter int ADDR_W    = 17,
    parameter int DATA_W    = 8,
    parameter int SETUP_CYC = 2,
    parameter int PULSE_CYC = 4,
    parameter int HOLD_CYC  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              ack,
    output logic              rd_msb,
    output logic              ce_n,
    output logic              oe_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    input  logic [DATA_W-1:0] dq_in
);
    localparam int M1    = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
    localparam int MAXC  = (M1 > HOLD_CYC) ? M1 : HOLD_CYC;
    localparam int CW    = $clog2(MAXC + 1);

    ewr_phase_e          ph;
    logic [CW-1:0]       cnt;
    logic                wr_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]   data_q;
    logic                unused_dq_low;

    assign unused_dq_low = ^dq_in[DATA_W-2:0];

    // Phase sequencing, request latching and read capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph     <= PH_IDLE;
            cnt    <= '0;
            ack    <= 1'b0;
            wr_q   <= 1'b0;
            addr_q <= '0;
            data_q <= '0;
            rd_msb <= 1'b0;
        end else begin
            ack <= 1'b0;
            unique case (ph)
                PH_IDLE: if (req) begin
                    ph     <= PH_SETUP;
                    cnt    <= '0;
                    wr_q   <= req_wr;
                    addr_q <= req_addr;
                    data_q <= req_data;
                end
                PH_SETUP: if (cnt == CW'(SETUP_CYC - 1)) begin
                    ph  <= PH_STROBE;
                    cnt <= '0;
                end else cnt <= cnt + 1'b1;
                PH_STROBE: if (cnt == CW'(PULSE_CYC - 1)) begin
                    if (!wr_q) rd_msb <= dq_in[DATA_W-1];
                    ph  <= PH_HOLD;
                    cnt <= '0;
                end else cnt <= cnt + 1'b1;
                PH_HOLD: if (cnt == CW'(HOLD_CYC - 1)) begin
                    ph  <= PH_IDLE;
                    cnt <= '0;
                    ack <= 1'b1;
                end else cnt <= cnt + 1'b1;
                default: ph <= PH_IDLE;
            endcase
        end
    end

    // Pin levels decoded from the current phase.
    always_comb begin
        ce_n   = (ph == PH_IDLE);
        we_n   = !((ph == PH_STROBE) && wr_q);
        oe_n   = !((ph == PH_STROBE) && !wr_q);
        dq_oe  = (ph != PH_IDLE) && wr_q;
        addr   = addr_q;
        dq_out = data_q;
    end

    p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !oe_n));
    p_strobe_in_select_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n || !oe_n) |-> !ce_n);
    p_addr_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && $past(!ce_n)) |-> $stable(addr));
    p_ack_after_select_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (ce_n && $past(!ce_n)));
endmodule

// File: rtl/ewr_sequencer.sv
// Burst sequencer: checks the request, issues the three unlock writes,
// moves stream bytes into the page, then polls for completion.
// Assumes: one bus request is outstanding at a time (pend flag); the bus
// engine acks only after a request it accepted while idle.
module ewr_sequencer
    import ewr_pkg::*;
#(
    parameter int ADDR_W    = 17,
    parameter int DATA_W    = 8,
    parameter int MAX_BYTES = 128,
    parameter int GAP_LIMIT = 15000,
    parameter int POLL_MAX  = 4000,
    parameter logic [ADDR_W-1:0] UNLOCK_ADDR_0 = 'h05555,
    parameter logic [ADDR_W-1:0] UNLOCK_ADDR_1 = 'h02AAA,
    parameter logic [ADDR_W-1:0] UNLOCK_ADDR_2 = 'h05555,
    parameter logic [DATA_W-1:0] UNLOCK_DATA_0 = 'hAA,
    parameter logic [DATA_W-1:0] UNLOCK_DATA_1 = 'h55,
    parameter logic [DATA_W-1:0] UNLOCK_DATA_2 = 'hA0,
    localparam int OFF_W  = $clog2(MAX_BYTES),
    localparam int PAGE_W = ADDR_W - OFF_W,
    localparam int CNT_W  = OFF_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_valid,
    input  logic [PAGE_W-1:0] start_page,
    input  logic [OFF_W-1:0]  start_offset,
    input  logic [CNT_W-1:0]  start_count,
    input  logic              s_valid,
    input  logic [DATA_W-1:0] s_data,
    output logic              s_ready,
    output logic              bus_req,
    output logic              bus_wr,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_data,
    input  logic              bus_ack,
    input  logic              bus_rd_msb,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [1:0]        err_code
);
    localparam int SPAN_W = CNT_W + 1;
    localparam int GAP_W  = $clog2(GAP_LIMIT + 1);
    localparam int POLL_W = $clog2(POLL_MAX + 1);

    ewr_seq_e          state;
    logic [PAGE_W-1:0] page_q;
    logic [OFF_W-1:0]  cursor;
    logic [CNT_W-1:0]  remain;
    logic [1:0]        step;
    logic              pend;
    logic [ADDR_W-1:0] last_addr;
    logic              last_msb;
    logic [GAP_W-1:0]  gap_cnt;
    logic [POLL_W-1:0] poll_cnt;
    logic [SPAN_W-1:0] span;
    logic              bad_req;
    logic [ADDR_W-1:0] unlk_addr;
    logic [DATA_W-1:0] unlk_data;

    // Request legality: non-zero, within a page, not crossing its end.
    always_comb begin
        span    = SPAN_W'(start_offset) + SPAN_W'(start_count);
        bad_req = (start_count == '0) || (start_count > CNT_W'(MAX_BYTES))
                  || (span > SPAN_W'(MAX_BYTES));
    end

    // Unlock command selected by the current step.
    always_comb begin
        unique case (step)
            2'd0:    begin unlk_addr = UNLOCK_ADDR_0; unlk_data = UNLOCK_DATA_0; end
            2'd1:    begin unlk_addr = UNLOCK_ADDR_1; unlk_data = UNLOCK_DATA_1; end
            default: begin unlk_addr = UNLOCK_ADDR_2; unlk_data = UNLOCK_DATA_2; end
        endcase
    end

    // Bus request and stream ready for the present state.
    always_comb begin
        bus_req  = 1'b0;
        bus_wr   = 1'b1;
        bus_addr = '0;
        bus_data = '0;
        s_ready  = (state == SQ_LOAD) && !pend;
        unique case (state)
            SQ_UNLOCK: if (!pend) begin
                bus_req  = 1'b1;
                bus_addr = unlk_addr;
                bus_data = unlk_data;
            end
            SQ_LOAD: if (!pend && s_valid) begin
                bus_req  = 1'b1;
                bus_addr = {page_q, cursor};
                bus_data = s_data;
            end
            SQ_POLL: if (!pend && (poll_cnt != POLL_W'(POLL_MAX))) begin
                bus_req  = 1'b1;
                bus_wr   = 1'b0;
                bus_addr = last_addr;
            end
            default: ;
        endcase
    end

    assign busy = (state != SQ_IDLE);

    // Burst state machine with gap deadline and poll budget.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SQ_IDLE;
            page_q    <= '0;
            cursor    <= '0;
            remain    <= '0;
            step      <= '0;
            pend      <= 1'b0;
            last_addr <= '0;
            last_msb  <= 1'b0;
            gap_cnt   <= '0;
            poll_cnt  <= '0;
            done      <= 1'b0;
            err       <= 1'b0;
            err_code  <= ERR_NONE;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            unique case (state)
                SQ_IDLE: if (start_valid) begin
                    if (bad_req) begin
                        err      <= 1'b1;
                        err_code <= ERR_REQ;
                    end else begin
                        state    <= SQ_UNLOCK;
                        page_q   <= start_page;
                        cursor   <= start_offset;
                        remain   <= start_count;
                        step     <= '0;
                        pend     <= 1'b0;
                        poll_cnt <= '0;
                    end
                end
                SQ_UNLOCK: begin
                    if (bus_req) pend <= 1'b1;
                    else if (bus_ack) begin
                        pend <= 1'b0;
                        if (step == 2'd2) begin
                            state   <= SQ_LOAD;
                            gap_cnt <= '0;
                        end else step <= step + 1'b1;
                    end
                end
                SQ_LOAD: begin
                    if (bus_req) begin
                        pend      <= 1'b1;
                        last_addr <= bus_addr;
                        last_msb  <= s_data[DATA_W-1];
                        cursor    <= cursor + 1'b1;
                        remain    <= remain - 1'b1;
                        gap_cnt   <= '0;
                    end else if (bus_ack) begin
                        pend    <= 1'b0;
                        gap_cnt <= '0;
                        if (remain == '0) state <= SQ_POLL;
                    end else if (!pend) begin
                        if (gap_cnt == GAP_W'(GAP_LIMIT - 1)) begin
                            state    <= SQ_IDLE;
                            err      <= 1'b1;
                            err_code <= ERR_GAP;
                        end else gap_cnt <= gap_cnt + 1'b1;
                    end
                end
                SQ_POLL: begin
                    if (bus_req) begin
                        pend     <= 1'b1;
                        poll_cnt <= poll_cnt + 1'b1;
                    end else if (bus_ack) begin
                        pend <= 1'b0;
                        if (bus_rd_msb == last_msb) begin
                            state <= SQ_IDLE;
                            done  <= 1'b1;
                        end
                    end else if (!pend && (poll_cnt == POLL_W'(POLL_MAX))) begin
                        state    <= SQ_IDLE;
                        err      <= 1'b1;
                        err_code <= ERR_POLL;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    p_reject_stays_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start_valid && bad_req) |=> (err && !busy));
    p_ready_in_burst_r6: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> busy);
    p_outcome_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));
    p_poll_budget_r9: assert property (@(posedge clk) disable iff (!rst_n)
        poll_cnt <= POLL_W'(POLL_MAX));
    p_end_drops_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done || err) |-> !busy);
    p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start_valid) |=> $stable(page_q));
endmodule

// File: rtl/eeprom_page_writer.sv
// Top: page-write sequencer for a byte-wide paged nonvolatile memory.
// Connects the burst sequencer to the pin-level cycle engine.
// Assumes: a single memory device on the pins; mem_dq_in is valid while
// mem_oe_n and mem_ce_n are low.
module eeprom_page_writer
    import ewr_pkg::*;
#(
    parameter int ADDR_W    = 17,
    parameter int DATA_W    = 8,
    parameter int MAX_BYTES = 128,
    parameter int SETUP_CYC = 2,
    parameter int PULSE_CYC = 4,
    parameter int HOLD_CYC  = 2,
    parameter int GAP_LIMIT = 15000,
    parameter int POLL_MAX  = 4000,
    parameter logic [ADDR_W-1:0] UNLOCK_ADDR_0 = 'h05555,
    parameter logic [ADDR_W-1:0] UNLOCK_ADDR_1 = 'h02AAA,
    parameter logic [ADDR_W-1:0] UNLOCK_ADDR_2 = 'h05555,
    parameter logic [DATA_W-1:0] UNLOCK_DATA_0 = 'hAA,
    parameter logic [DATA_W-1:0] UNLOCK_DATA_1 = 'h55,
    parameter logic [DATA_W-1:0] UNLOCK_DATA_2 = 'hA0,
    localparam int OFF_W  = $clog2(MAX_BYTES),
    localparam int PAGE_W = ADDR_W - OFF_W,
    localparam int CNT_W  = OFF_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_valid,
    input  logic [PAGE_W-1:0] start_page,
    input  logic [OFF_W-1:0]  start_offset,
    input  logic [CNT_W-1:0]  start_count,
    input  logic              s_valid,
    input  logic [DATA_W-1:0] s_data,
    output logic              s_ready,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [1:0]        err_code
);
    logic              bus_req;
    logic              bus_wr;
    logic [ADDR_W-1:0] bus_addr;
    logic [DATA_W-1:0] bus_data;
    logic              bus_ack;
    logic              bus_rd_msb;

    ewr_sequencer #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_BYTES(MAX_BYTES),
        .GAP_LIMIT(GAP_LIMIT), .POLL_MAX(POLL_MAX),
        .UNLOCK_ADDR_0(UNLOCK_ADDR_0), .UNLOCK_ADDR_1(UNLOCK_ADDR_1),
        .UNLOCK_ADDR_2(UNLOCK_ADDR_2), .UNLOCK_DATA_0(UNLOCK_DATA_0),
        .UNLOCK_DATA_1(UNLOCK_DATA_1), .UNLOCK_DATA_2(UNLOCK_DATA_2)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .start_valid(start_valid), .start_page(start_page),
        .start_offset(start_offset), .start_count(start_count),
        .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
        .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_data(bus_data), .bus_ack(bus_ack), .bus_rd_msb(bus_rd_msb),
        .busy(busy), .done(done), .err(err), .err_code(err_code)
    );

    ewr_bus_cycle #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC), .HOLD_CYC(HOLD_CYC)
    ) u_bus (
        .clk(clk), .rst_n(rst_n),
        .req(bus_req), .req_wr(bus_wr), .req_addr(bus_addr), .req_data(bus_data),
        .ack(bus_ack), .rd_msb(bus_rd_msb),
        .ce_n(mem_ce_n), .oe_n(mem_oe_n), .we_n(mem_we_n),
        .addr(mem_addr), .dq_out(mem_dq_out), .dq_oe(mem_dq_oe),
        .dq_in(mem_dq_in)
    );

    p_reset_idle_pins_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe));
endmodule

// File: tb/eeprom_page_writer_test.sv
`timescale 1ns/1ps
module eeprom_page_writer_test;
    localparam int SETUP = 2;
    localparam int PULSE = 3;
    localparam int HOLD  = 1;
    localparam int GAP   = 40;
    localparam int PMAX  = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_valid = 1'b0;
    logic [9:0]  start_page = '0;
    logic [6:0]  start_offset = '0;
    logic [7:0]  start_count = '0;
    logic        s_valid = 1'b0;
    logic [7:0]  s_data = '0;
    logic        s_ready;
    logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [16:0] mem_addr;
    logic [7:0]  mem_dq_out, mem_dq_in;
    logic        busy, done, err;
    logic [1:0]  err_code;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    eeprom_page_writer #(
        .SETUP_CYC(SETUP), .PULSE_CYC(PULSE), .HOLD_CYC(HOLD),
        .GAP_LIMIT(GAP), .POLL_MAX(PMAX)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start_valid(start_valid),
        .start_page(start_page), .start_offset(start_offset),
        .start_count(start_count), .s_valid(s_valid), .s_data(s_data),
        .s_ready(s_ready), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in), .busy(busy),
        .done(done), .err(err), .err_code(err_code)
    );

    // Memory model: logs writes, measures strobe timing, answers polls.
    logic [16:0] wlog_addr [0:511];
    logic [7:0]  wlog_data [0:511];
    int   wcount = 0, reads_done = 0, busy_reads = 0, ce_falls = 0;
    int   ce_run = 0, we_run = 0;
    bit   timing_bad = 1'b0;
    logic we_q = 1'b1, oe_q = 1'b1, ce_q = 1'b1;
    logic [7:0] last_wr = '0;

    assign mem_dq_in = (reads_done < busy_reads) ? {~last_wr[7], last_wr[6:0]} : last_wr;

    always @(posedge clk) begin
        ce_run <= mem_ce_n ? 0 : ce_run + 1;
        we_run <= mem_we_n ? 0 : we_run + 1;
        if (ce_q && !mem_ce_n) ce_falls <= ce_falls + 1;
        if (we_q && !mem_we_n && ce_run != SETUP) timing_bad <= 1'b1;
        if (!mem_we_n && !mem_oe_n) timing_bad <= 1'b1;
        if (!we_q && mem_we_n) begin
            if (we_run != PULSE || !mem_dq_oe || mem_ce_n) timing_bad <= 1'b1;
            if (wcount < 512) begin
                wlog_addr[wcount] <= mem_addr;
                wlog_data[wcount] <= mem_dq_out;
            end
            wcount     <= wcount + 1;
            last_wr    <= mem_dq_out;
            reads_done <= 0;
        end
        if (!oe_q && mem_oe_n) reads_done <= reads_done + 1;
        we_q <= mem_we_n;
        oe_q <= mem_oe_n;
        ce_q <= mem_ce_n;
    end

    function automatic logic [7:0] pat(int seed, int i);
        return 8'(seed * 37 + i * 13 + (i >> 3));
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic launch(int page, int off, int cnt);
        @(negedge clk);
        start_page   = 10'(page);
        start_offset = 7'(off);
        start_count  = 8'(cnt);
        start_valid  = 1'b1;
        @(negedge clk);
        start_valid  = 1'b0;
    endtask

    task automatic feed(int n, int stall, int seed);
        @(negedge clk);
        for (int i = 0; i < n; i++) begin
            s_data  = pat(seed, i);
            s_valid = 1'b1;
            while (!s_ready) @(negedge clk);
            @(negedge clk);
            s_valid = 1'b0;
            repeat (stall) @(negedge clk);
        end
    endtask

    task automatic wait_end(output bit got_done, output bit got_err, output int code);
        got_done = 0; got_err = 0; code = 0;
        for (int c = 0; c < 3000; c++) begin
            @(negedge clk);
            if (done || err) begin
                got_done = done; got_err = err; code = int'(err_code);
                check(!busy, "R10", "busy low in end cycle", int'(busy), 0);
                return;
            end
        end
        check(0, "R10", "burst never ended", 0, 1);
    endtask

    task automatic check_log(int base, int page, int off, int cnt, int seed, string tag);
        check(wcount - base == 3 + cnt, "R3", {tag, " write count"}, wcount - base, 3 + cnt);
        check(wlog_addr[base] == 17'h05555 && wlog_data[base] == 8'hAA, "R3", {tag, " unlock 1"}, int'(wlog_data[base]), 'hAA);
        check(wlog_addr[base+1] == 17'h02AAA && wlog_data[base+1] == 8'h55, "R3", {tag, " unlock 2"}, int'(wlog_data[base+1]), 'h55);
        check(wlog_addr[base+2] == 17'h05555 && wlog_data[base+2] == 8'hA0, "R3", {tag, " unlock 3"}, int'(wlog_data[base+2]), 'hA0);
        for (int i = 0; i < cnt; i++) begin
            logic [16:0] ea = {10'(page), 7'(off + i)};
            if (wlog_addr[base+3+i] != ea)
                check(0, "R4", {tag, " data address"}, int'(wlog_addr[base+3+i]), int'(ea));
            if (wlog_data[base+3+i] != pat(seed, i))
                check(0, "R6", {tag, " data order"}, int'(wlog_data[base+3+i]), int'(pat(seed, i)));
        end
        check(1, "R4", {tag, " data log scanned"}, 0, 0);
    endtask

    task automatic t_reset();
        check(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe, "R1", "pins idle", int'({mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}), 'b1110);
        check(!busy && !done && !err && !s_ready, "R1", "status idle", int'({busy, done, err, s_ready}), 0);
    endtask

    task automatic t_basic();
        int base = wcount; bit d, e; int code;
        busy_reads = 2;
        fork feed(4, 0, 1); join_none
        launch(10'h155, 0, 4);
        check(busy, "R10", "busy after accept", int'(busy), 1);
        wait_end(d, e, code);
        wait fork;
        check(d && !e, "R8", "basic done", int'({d, e}), 'b10);
        check(reads_done == 3, "R8", "basic poll reads", reads_done, 3);
        check_log(base, 'h155, 0, 4, 1, "basic");
    endtask

    task automatic t_full_page();
        int base = wcount; bit d, e; int code;
        busy_reads = 1;
        fork feed(128, 3, 2); join_none
        launch(10'h2A3, 0, 128);
        wait_end(d, e, code);
        wait fork;
        check(d && !e, "R4", "full page done", int'({d, e}), 'b10);
        check_log(base, 'h2A3, 0, 128, 2, "full");
    endtask

    task automatic t_tail();
        int base = wcount; bit d, e; int code;
        busy_reads = 0;
        fork feed(8, 1, 3); join_none
        launch(10'h001, 120, 8);
        wait_end(d, e, code);
        wait fork;
        check(d && !e, "R4", "tail offset+count=128 done", int'({d, e}), 'b10);
        check_log(base, 'h001, 120, 8, 3, "tail");
    endtask

    task automatic t_reject(int off, int cnt, string tag);
        int base = wcount; int cf = ce_falls;
        launch(10'h3FF, off, cnt);
        check(err && err_code == 2'd1, "R2", {tag, " err code"}, int'({err, err_code}), 'b101);
        check(!busy, "R2", {tag, " busy stays low"}, int'(busy), 0);
        repeat (10) @(negedge clk);
        check(ce_falls == cf && wcount == base, "R2", {tag, " no pin activity"}, ce_falls - cf, 0);
    endtask

    task automatic t_gap();
        int base = wcount; bit d, e; int code;
        busy_reads = 0;
        fork feed(2, 0, 4); join_none
        launch(10'h077, 10, 5);
        wait_end(d, e, code);
        wait fork;
        check(e && code == 2, "R7", "gap error code", code, 2);
        repeat (20) @(negedge clk);
        check(wcount - base == 5, "R7", "no write after gap", wcount - base, 5);
        check(!busy && mem_ce_n, "R7", "idle after gap", int'({busy, mem_ce_n}), 'b01);
    endtask

    task automatic t_poll(int br, bit expect_done);
        bit d, e; int code;
        busy_reads = br;
        fork feed(3, 0, 5); join_none
        launch(10'h040, 64, 3);
        wait_end(d, e, code);
        wait fork;
        if (expect_done) begin
            check(d && !e, "R9", "match on last allowed read", int'({d, e}), 'b10);
        end else begin
            check(e && code == 3, "R9", "poll limit error", code, 3);
        end
        check(reads_done == PMAX, "R9", "poll read count", reads_done, PMAX);
    endtask

    task automatic t_start_busy();
        int base = wcount; bit d, e; int code;
        busy_reads = 1;
        fork feed(6, 2, 6); join_none
        launch(10'h111, 4, 6);
        repeat (15) @(negedge clk);
        launch(10'h222, 0, 3);
        wait_end(d, e, code);
        wait fork;
        check(d && !e, "R10", "first burst completes", int'({d, e}), 'b10);
        check_log(base, 'h111, 4, 6, 6, "busy-start");
        repeat (20) @(negedge clk);
        check(wcount - base == 9 && !busy, "R10", "second start ignored", wcount - base, 9);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_reject(0, 0, "count zero");
        t_reject(0, 129, "count over");
        t_reject(100, 40, "crosses page");
        t_full_page();
        t_tail();
        t_gap();
        t_poll(PMAX - 1, 1'b1);
        t_poll(PMAX, 1'b0);
        t_start_busy();
        check(!timing_bad, "R5", "strobe setup/width/overlap", int'(timing_bad), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule